// File: doc/BRIEF.md
# Flash Data-Polling Status Generator

This block produces the polled status bit that a flash array returns on its top data line while an embedded program or erase runs. A command decoder pulses `op_start` in the cycle of the final write strobe of a program or erase sequence. With that pulse it supplies the operation kind, the target word address and its bit 7, the sectors selected for erase, and the per-sector protection flags. The embedded engine reports progress on `eng_busy` and reports erase suspend on `ers_susp`. Reads arrive as a stream. Each read carries an address and the bit 7 that the array holds at that address. The block answers each read with the polled bit, a flag that says whether the bit is status or true data, and a trust flag.

Sector numbers come from the top log2(NSEC) bits of an address. For a buffer program, `op_addr` is the last word of the page, and only reads at that word are trusted. Protection and the erase selection are captured at `op_start`.

The read request and the response are valid/ready channels. `rd_ready` is high when no response is waiting or when the waiting response is being taken in the same cycle. A response appears one cycle after its request is accepted. It stays unchanged until `rsp_ready` is high, so a completion that occurs during a stalled read cannot alter a value already sampled.

Top module: `dpoll_status`

## Requirements
- R1: A read accepted on a rising edge produces `rsp_valid`=1 after that edge. While `rsp_valid`=1 and `rsp_ready`=0, the response fields stay unchanged and `rd_ready`=0. After reset, `rsp_valid`=0 and `rd_ready`=1.
- R2: With no operation active, including every read before the `op_start` cycle, the response is `rsp_dq7`=`arr_bit7`, `rsp_stat`=0 and `rsp_trust`=1.
- R3: From the first read accepted after the `op_start` cycle of a program (`op_erase`=0), a read at `op_addr` returns `rsp_dq7`= NOT `op_bit7`, `rsp_stat`=1 and `rsp_trust`=1.
- R4: While a program is active, a read at any address other than `op_addr`, such as another word of the buffer page, returns `rsp_stat`=1 and `rsp_trust`=0.
- R5: A program ends on the first falling edge of `eng_busy`. Reads after that return array data as in R2.
- R6: While an erase is running, a read inside a selected, unprotected sector returns `rsp_dq7`=0, or 1 while `ers_susp`=1, with `rsp_stat`=1 and `rsp_trust`=1.
- R7: While an erase is running, a read in a protected sector or in a sector that was not selected returns `rsp_stat`=1 and `rsp_trust`=0.
- R8: An erase ends on a falling edge of `eng_busy` while `ers_susp`=0. A falling edge while `ers_susp`=1 leaves the erase active.
- R9: If every selected sector is protected, reads in the selected sectors return `rsp_dq7`=0, `rsp_stat`=1 and `rsp_trust`=1 for CLK_MHZ*ERASE_PROT_US cycles, whatever `eng_busy` does. After that, reads return to R2.
- R10: A program aimed at a protected sector returns the R3 status for CLK_MHZ*PROG_PROT_US cycles. After that, reads return to R2.
- R11: A program issued during erase suspend takes priority over erase status under R3/R4. When the program ends, reads return to the suspended erase status of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Final write strobe of a command sequence |
| op_erase | input | 1 | 1 = erase, 0 = program |
| op_addr | input | AW | Program word address (last word of a buffer page) |
| op_bit7 | input | 1 | Bit 7 of the datum being programmed |
| erase_sel | input | NSEC | Sectors selected for erase |
| sect_prot | input | NSEC | Per-sector protection flags |
| eng_busy | input | 1 | Embedded engine busy |
| ers_susp | input | 1 | Erase suspended |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request ready |
| rd_addr | input | AW | Read address |
| arr_bit7 | input | 1 | Array bit 7 at the read address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_dq7 | output | 1 | Polled bit or true data bit |
| rsp_trust | output | 1 | Returned bit is reliable |
| rsp_stat | output | 1 | 1 = status, 0 = array data |

## Verification
A vector table sets up one operation after each reset and reads once. It covers idle reads with both array values, program status for both datum polarities at the target word, at a neighbouring word and in another sector, and erase reads in selected, protected and unselected sectors. Together these separate the inversion rule, the erase 0/1 rule and the trust qualifier. Directed sequences then show that program completion and erase completion follow busy falling edges, and that a busy fall during suspend does not end the erase. They also cover a program nested in a suspend, both protected windows before and after expiry, and a stalled response that must not change while a second request waits.

// File: rtl/dpoll_pkg.sv
package dpoll_pkg;
  typedef struct packed {
    logic dq7;
    logic trust;
    logic stat;
  } dpoll_rsp_t;
endpackage

// File: rtl/dpoll_secdec.sv
module dpoll_secdec #(
  parameter int AW   = 16,
  parameter int NSEC = 8
) (
  input  logic [AW-1:0]   addr,
  output logic [NSEC-1:0] onehot
);
  localparam int SW = $clog2(NSEC);

  logic [SW-1:0] idx;
  assign idx = addr[AW-1 -: SW];

  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    assign onehot[g] = (idx == SW'(g));
  end
endmodule

// File: rtl/dpoll_tracker.sv
module dpoll_tracker #(
  parameter int AW     = 16,
  parameter int NSEC   = 8,
  parameter int EP_CYC = 10000,
  parameter int PP_CYC = 100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_start,
  input  logic            op_erase,
  input  logic [AW-1:0]   op_addr,
  input  logic            op_bit7,
  input  logic            op_in_prot,
  input  logic [NSEC-1:0] erase_sel,
  input  logic [NSEC-1:0] sect_prot,
  input  logic            eng_busy,
  input  logic            ers_susp,
  output logic            prog_ctx,
  output logic [AW-1:0]   p_addr,
  output logic            p_bit7,
  output logic            ers_ctx,
  output logic            ers_run,
  output logic [NSEC-1:0] ers_mask
);
  localparam int EPW = $clog2(EP_CYC + 1);
  localparam int PPW = $clog2(PP_CYC + 1);

  logic           busy_q;
  logic           prog_run;
  logic [EPW-1:0] ep_cnt;
  logic [PPW-1:0] pp_cnt;
  logic [NSEC-1:0] eff;
  logic           busy_fall;

  assign eff       = erase_sel & ~sect_prot;
  assign busy_fall = busy_q & ~eng_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      prog_run <= 1'b0;
      ers_run  <= 1'b0;
      ep_cnt   <= '0;
      pp_cnt   <= '0;
      p_addr   <= '0;
      p_bit7   <= 1'b0;
      ers_mask <= '0;
    end else begin
      busy_q <= eng_busy;
      if (pp_cnt != '0) pp_cnt <= pp_cnt - 1'b1;
      if (ep_cnt != '0) ep_cnt <= ep_cnt - 1'b1;
      // a busy fall ends the foreground program first; erase only when not suspended
      if (busy_fall) begin
        if (prog_run) prog_run <= 1'b0;
        else if (ers_run && !ers_susp) ers_run <= 1'b0;
      end
      if (op_start) begin
        if (op_erase) begin
          if (eff == '0) begin
            ers_mask <= erase_sel;
            ers_run  <= 1'b0;
            ep_cnt   <= EPW'(EP_CYC);
          end else begin
            ers_mask <= eff;
            ers_run  <= 1'b1;
            ep_cnt   <= '0;
          end
        end else begin
          p_addr <= op_addr;
          p_bit7 <= op_bit7;
          if (op_in_prot) begin
            prog_run <= 1'b0;
            pp_cnt   <= PPW'(PP_CYC);
          end else begin
            prog_run <= 1'b1;
            pp_cnt   <= '0;
          end
        end
      end
    end
  end

  assign prog_ctx = prog_run | (pp_cnt != '0);
  assign ers_ctx  = ers_run | (ep_cnt != '0);
endmodule

// File: rtl/dpoll_rspreg.sv
module dpoll_rspreg
  import dpoll_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_valid,
  output logic       rd_ready,
  input  dpoll_rsp_t nxt,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output dpoll_rsp_t rsp
);
  assign rd_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp       <= '0;
    end else if (rd_ready) begin
      rsp_valid <= rd_valid;
      if (rd_valid) rsp <= nxt;
    end
  end
endmodule

// File: rtl/dpoll_status.sv
module dpoll_status
  import dpoll_pkg::*;
#(
  parameter int AW            = 16,
  parameter int NSEC          = 8,
  parameter int CLK_MHZ       = 100,
  parameter int ERASE_PROT_US = 100,
  parameter int PROG_PROT_US  = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_start,
  input  logic            op_erase,
  input  logic [AW-1:0]   op_addr,
  input  logic            op_bit7,
  input  logic [NSEC-1:0] erase_sel,
  input  logic [NSEC-1:0] sect_prot,
  input  logic            eng_busy,
  input  logic            ers_susp,
  input  logic            rd_valid,
  output logic            rd_ready,
  input  logic [AW-1:0]   rd_addr,
  input  logic            arr_bit7,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_dq7,
  output logic            rsp_trust,
  output logic            rsp_stat
);
  localparam int EP_CYC = CLK_MHZ * ERASE_PROT_US;
  localparam int PP_CYC = CLK_MHZ * PROG_PROT_US;

  logic [NSEC-1:0] rd_sec, op_sec, ers_mask;
  logic            prog_ctx, p_bit7, ers_ctx, ers_run;
  logic [AW-1:0]   p_addr;
  dpoll_rsp_t      nxt, rsp;

  dpoll_secdec #(.AW(AW), .NSEC(NSEC)) u_rdsec (.addr(rd_addr), .onehot(rd_sec));
  dpoll_secdec #(.AW(AW), .NSEC(NSEC)) u_opsec (.addr(op_addr), .onehot(op_sec));

  dpoll_tracker #(.AW(AW), .NSEC(NSEC), .EP_CYC(EP_CYC), .PP_CYC(PP_CYC)) u_trk (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_erase(op_erase),
    .op_addr(op_addr), .op_bit7(op_bit7), .op_in_prot(|(op_sec & sect_prot)),
    .erase_sel(erase_sel), .sect_prot(sect_prot), .eng_busy(eng_busy),
    .ers_susp(ers_susp), .prog_ctx(prog_ctx), .p_addr(p_addr), .p_bit7(p_bit7),
    .ers_ctx(ers_ctx), .ers_run(ers_run), .ers_mask(ers_mask)
  );

  // program status outranks erase status (program inside erase suspend)
  always_comb begin
    if (prog_ctx) begin
      nxt.dq7   = ~p_bit7;
      nxt.trust = (rd_addr == p_addr);
      nxt.stat  = 1'b1;
    end else if (ers_ctx) begin
      nxt.dq7   = ers_run & ers_susp;
      nxt.trust = |(rd_sec & ers_mask);
      nxt.stat  = 1'b1;
    end else begin
      nxt.dq7   = arr_bit7;
      nxt.trust = 1'b1;
      nxt.stat  = 1'b0;
    end
  end

  dpoll_rspreg u_rsp (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .nxt(nxt), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp(rsp)
  );

  assign rsp_dq7   = rsp.dq7;
  assign rsp_trust = rsp.trust;
  assign rsp_stat  = rsp.stat;
endmodule

// File: rtl/dpoll_status_chk.sv
module dpoll_status_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_start,
  input logic          op_erase,
  input logic [AW-1:0] op_addr,
  input logic          op_bit7,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic          rsp_dq7,
  input logic          rsp_trust,
  input logic          rsp_stat
);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_dq7) &&
                                   $stable(rsp_trust) && $stable(rsp_stat)));

  assert_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !rd_ready);

  assert_respond_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rsp_valid);

  assert_data_trusted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_stat) |-> rsp_trust);

  assert_prog_invert_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !op_start && $past(op_start && !op_erase) &&
     rd_addr == $past(op_addr))
    |=> (rsp_stat && rsp_trust && (rsp_dq7 == !$past(op_bit7, 2))));
endmodule

bind dpoll_status dpoll_status_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_erase(op_erase),
  .op_addr(op_addr), .op_bit7(op_bit7), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_addr(rd_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_dq7(rsp_dq7), .rsp_trust(rsp_trust),
  .rsp_stat(rsp_stat)
);

// File: tb/dpoll_status_tb.sv
module dpoll_status_tb;
  localparam int CLK_PERIOD = 10;
  localparam int EP_CYC = 100 * 100;
  localparam int PP_CYC = 100 * 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_start = 0, op_erase = 0, op_bit7 = 0;
  logic [15:0] op_addr = '0, rd_addr = '0;
  logic [7:0] erase_sel = '0, sect_prot = '0;
  logic eng_busy = 0, ers_susp = 0, rd_valid = 0, arr_bit7 = 0, rsp_ready = 1;
  logic rd_ready, rsp_valid, rsp_dq7, rsp_trust, rsp_stat;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dpoll_status u_dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_erase(op_erase),
    .op_addr(op_addr), .op_bit7(op_bit7), .erase_sel(erase_sel),
    .sect_prot(sect_prot), .eng_busy(eng_busy), .ers_susp(ers_susp),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .arr_bit7(arr_bit7), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_dq7(rsp_dq7), .rsp_trust(rsp_trust), .rsp_stat(rsp_stat)
  );

  // kind: 0 none, 1 program, 2 erase; sector = addr[15:13]
  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] oaddr;
    logic        obit;
    logic [7:0]  sel;
    logic [7:0]  prot;
    logic [15:0] raddr;
    logic        arr;
    logic        edq;
    logic        etr;
    logic        est;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{2'd0, 16'h0000, 1'b0, 8'h00, 8'h00, 16'h2010, 1'b1, 1'b1, 1'b1, 1'b0, 4'd2},  // R2
    '{2'd0, 16'h0000, 1'b0, 8'h00, 8'h00, 16'h2010, 1'b0, 1'b0, 1'b1, 1'b0, 4'd2},  // R2
    '{2'd1, 16'h2010, 1'b1, 8'h00, 8'h00, 16'h2010, 1'b1, 1'b0, 1'b1, 1'b1, 4'd3},  // R3
    '{2'd1, 16'h2010, 1'b0, 8'h00, 8'h00, 16'h2010, 1'b0, 1'b1, 1'b1, 1'b1, 4'd3},  // R3
    '{2'd1, 16'h2010, 1'b1, 8'h00, 8'h00, 16'h2011, 1'b1, 1'b0, 1'b0, 1'b1, 4'd4},  // R4
    '{2'd1, 16'h2010, 1'b0, 8'h00, 8'h00, 16'h4000, 1'b0, 1'b1, 1'b0, 1'b1, 4'd4},  // R4
    '{2'd2, 16'h0000, 1'b0, 8'h02, 8'h00, 16'h2000, 1'b1, 1'b0, 1'b1, 1'b1, 4'd6},  // R6
    '{2'd2, 16'h0000, 1'b0, 8'h06, 8'h04, 16'h4000, 1'b1, 1'b0, 1'b0, 1'b1, 4'd7},  // R7
    '{2'd2, 16'h0000, 1'b0, 8'h02, 8'h00, 16'hE000, 1'b1, 1'b0, 1'b0, 1'b1, 4'd7},  // R7
    '{2'd2, 16'h0000, 1'b0, 8'h06, 8'h06, 16'h2000, 1'b1, 1'b0, 1'b1, 1'b1, 4'd9},  // R9
    '{2'd1, 16'h2010, 1'b1, 8'h00, 8'h02, 16'h2010, 1'b1, 1'b0, 1'b1, 1'b1, 4'd10}  // R10
  };

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic chk_rsp(string tag, logic edq, logic etr, logic est);
    chk(tag, rsp_valid, 1'b1, "rsp_valid");
    chk(tag, {rsp_dq7, rsp_trust, rsp_stat} == {edq, etr, est}, 1'b1,
        $sformatf("dq7/trust/stat=%b%b%b want %b%b%b", rsp_dq7, rsp_trust, rsp_stat, edq, etr, est));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; op_start = 0; rd_valid = 0; eng_busy = 0; ers_susp = 0; rsp_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic issue(logic erase, logic [15:0] a, logic b, logic [7:0] sel, logic [7:0] prot);
    @(negedge clk);
    op_start = 1; op_erase = erase; op_addr = a; op_bit7 = b;
    erase_sel = sel; sect_prot = prot; eng_busy = 1;
    @(negedge clk);
    op_start = 0;
  endtask

  // request accepted at the next edge; response sampled at the following negedge
  task automatic do_read(logic [15:0] a, logic arr);
    rd_valid = 1; rd_addr = a; arr_bit7 = arr;
    @(negedge clk);
    rd_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    do_reset();
    chk("R1", rsp_valid, 1'b0, "reset rsp_valid");
    chk("R1", rd_ready, 1'b1, "reset rd_ready");

    for (int i = 0; i < NV; i++) begin
      do_reset();
      if (VT[i].kind == 2'd1) issue(1'b0, VT[i].oaddr, VT[i].obit, 8'h00, VT[i].prot);
      else if (VT[i].kind == 2'd2) issue(1'b1, 16'h0000, 1'b0, VT[i].sel, VT[i].prot);
      do_read(VT[i].raddr, VT[i].arr);
      chk_rsp($sformatf("R%0d vec%0d", VT[i].req, i), VT[i].edq, VT[i].etr, VT[i].est);
    end

    // R2: read in the same cycle as the final strobe still sees read mode
    do_reset();
    @(negedge clk);
    op_start = 1; op_erase = 0; op_addr = 16'h2010; op_bit7 = 1; sect_prot = 0; eng_busy = 1;
    rd_valid = 1; rd_addr = 16'h2010; arr_bit7 = 1;
    @(negedge clk);
    op_start = 0; rd_valid = 0;
    chk_rsp("R2 pre-strobe", 1'b1, 1'b1, 1'b0);

    // R5: program ends on busy fall
    do_reset();
    issue(1'b0, 16'h2010, 1'b1, 8'h00, 8'h00);
    do_read(16'h2010, 1'b1);
    chk_rsp("R5 busy", 1'b0, 1'b1, 1'b1);
    eng_busy = 0;
    @(negedge clk);
    do_read(16'h2010, 1'b1);
    chk_rsp("R5 done", 1'b1, 1'b1, 1'b0);

    // R8 / R11: suspend, nested program, resume, completion
    do_reset();
    issue(1'b1, 16'h0000, 1'b0, 8'h02, 8'h00);
    ers_susp = 1; eng_busy = 0;
    @(negedge clk);
    do_read(16'h2000, 1'b0);
    chk_rsp("R8 suspended erase", 1'b1, 1'b1, 1'b1);
    issue(1'b0, 16'h4010, 1'b1, 8'h02, 8'h00);
    do_read(16'h4010, 1'b1);
    chk_rsp("R11 prog in suspend", 1'b0, 1'b1, 1'b1);
    eng_busy = 0;
    @(negedge clk);
    do_read(16'h2000, 1'b0);
    chk_rsp("R11 back to erase", 1'b1, 1'b1, 1'b1);
    ers_susp = 0; eng_busy = 1;
    @(negedge clk);
    do_read(16'h2000, 1'b0);
    chk_rsp("R6 resumed erase", 1'b0, 1'b1, 1'b1);
    eng_busy = 0;
    @(negedge clk);
    do_read(16'h2000, 1'b1);
    chk_rsp("R8 erase done", 1'b1, 1'b1, 1'b0);

    // R9: all-protected window, busy dropped early
    do_reset();
    issue(1'b1, 16'h0000, 1'b0, 8'h02, 8'h02);
    eng_busy = 0;
    repeat (EP_CYC / 2) @(negedge clk);
    do_read(16'h2000, 1'b1);
    chk_rsp("R9 window", 1'b0, 1'b1, 1'b1);
    repeat (EP_CYC / 2 + 5) @(negedge clk);
    do_read(16'h2000, 1'b1);
    chk_rsp("R9 expired", 1'b1, 1'b1, 1'b0);

    // R10: protected program window
    do_reset();
    issue(1'b0, 16'h2010, 1'b0, 8'h00, 8'h02);
    eng_busy = 0;
    repeat (PP_CYC / 2) @(negedge clk);
    do_read(16'h2010, 1'b0);
    chk_rsp("R10 window", 1'b1, 1'b1, 1'b1);
    repeat (PP_CYC / 2 + 5) @(negedge clk);
    do_read(16'h2010, 1'b0);
    chk_rsp("R10 expired", 1'b0, 1'b1, 1'b0);

    // R1: back-pressure keeps the response and stalls the next request
    do_reset();
    rsp_ready = 0;
    rd_valid = 1; rd_addr = 16'h2010; arr_bit7 = 1;
    @(negedge clk);
    arr_bit7 = 0;
    chk_rsp("R1 first", 1'b1, 1'b1, 1'b0);
    chk("R1", rd_ready, 1'b0, "stalled rd_ready");
    repeat (3) @(negedge clk);
    chk("R1", rsp_dq7, 1'b1, "held rsp_dq7");
    chk("R1", rd_ready, 1'b0, "still stalled");
    rsp_ready = 1;
    @(negedge clk);
    rd_valid = 0;
    chk_rsp("R1 second", 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    chk("R1", rsp_valid, 1'b0, "drained rsp_valid");

    finish_run();
  end
endmodule